// File: doc/BRIEF.md
# Latency-Driven Decode Interlock

This unit sits beside the decode stage of an in-order, single-issue pipeline that forwards every result as soon as it exists. For the instruction waiting in decode it works out how many bubble cycles must go in front of it. The answer depends on three things: the class of the instruction that last wrote each source register, the class of the consumer, and how many issue slots have gone by since that producer left decode. A lookup of minimum producer-to-consumer distances replaces a single load-use rule. Some pairs cost nothing. A double load that feeds a double store is one of them.

The unit keeps a short shift history of recently issued slots. Each slot holds a write-valid flag, the destination register and the instruction class. Bubbles enter the history as empty slots, so a pending requirement counts down by one every cycle. While a requirement is pending the unit holds the decode instruction and reports the remaining count. It lets the instruction go in the cycle where the count is zero. A branch resolves in decode. If the branch does not fill its single delay slot, the unit raises a one-cycle control penalty and holds the following instruction for that cycle.

Top module: `ilk_interlock_unit`

## Requirements
- R1: After reset the history is empty. With no instruction in decode, stall, issue, ctl_penalty and stall_cnt are all 0, and the first instruction after reset issues without stalling whatever its sources are.
- R2: A result of an FP ALU operation (class code 0) read by another FP ALU operation needs 3 empty slots between the two issues.
- R3: A result of an FP ALU operation read by a double store (class code 2) needs 2 empty slots.
- R4: A result of a double load (class code 1) read by an FP ALU operation needs 1 empty slot.
- R5: A double load result read by a double store needs no empty slot.
- R6: An integer ALU result (class code 3) read by a branch (class code 4) needs 1 empty slot.
- R7: Every other producer/consumer class pair needs no empty slot, for example FP ALU feeding integer ALU, or integer ALU feeding FP ALU.
- R8: The stall for a source equals its required distance minus the issue slots (instructions or bubbles) already between producer and consumer. It is never below zero.
- R9: When both sources have pending producers, the stall is the larger of the two requirements.
- R10: Only the most recent writer of a register sets the requirement for a read of that register.
- R11: While stall_cnt is nonzero the decode instruction is held (issue is 0). With the descriptor unchanged, stall_cnt drops by exactly one per cycle, and the instruction issues in the first cycle where stall_cnt is 0.
- R12: When a branch issues with dec_slot_used = 0, ctl_penalty is 1 for exactly the next cycle and an instruction in decode in that cycle is held. A branch with dec_slot_used = 1 causes no penalty.
- R13: A source whose valid bit is 0 never causes a stall, and an instruction issued with dec_dst_we = 0 never becomes a producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_cls | input | 3 | Class: 0 FP ALU, 1 load double, 2 store double, 3 integer ALU, 4 branch |
| dec_dst | input | REG_W | Destination register |
| dec_dst_we | input | 1 | Instruction writes dec_dst |
| dec_src_a | input | REG_W | First source register |
| dec_src_a_vld | input | 1 | First source is read |
| dec_src_b | input | REG_W | Second source register |
| dec_src_b_vld | input | 1 | Second source is read |
| dec_slot_used | input | 1 | A branch in decode fills its delay slot |
| stall | output | 1 | Decode instruction held this cycle |
| issue | output | 1 | Decode instruction leaves this cycle |
| stall_cnt | output | CNT_W | Stall cycles still required |
| ctl_penalty | output | 1 | Control bubble after a branch with an unused slot |

## Verification
The bench covers the corner cases that expose an off-by-one or a missing case. It checks FP producers aged by idle gaps of two and four cycles: a unit that does not count bubbles would stall too long, and one that counts from the wrong slot would release one cycle early. It checks the zero-cost pair of load feeding store, which a unit with a single load-use rule would stall. It covers a register written by an FP operation and then by a load: a unit that searched oldest-first would charge 2 cycles instead of 1. It covers two pending sources, where taking the first match instead of the maximum gives 1 instead of 2. It also checks branches with and without a filled slot, unread sources, non-writing producers, and a reset issued while a producer is still pending.

// File: rtl/ilk_pkg.sv
// Package: shared instruction-class encoding and the latency lookup.
// Assumes the five class codes below are what decode presents on dec_cls.
package ilk_pkg;

    typedef enum logic [2:0] {
        CLS_FPALU  = 3'd0,
        CLS_LOADD  = 3'd1,
        CLS_STORED = 3'd2,
        CLS_INTALU = 3'd3,
        CLS_BRANCH = 3'd4
    } iclass_e;

    // Minimum empty slots between producer and consumer issue.
    function automatic int pair_latency(
        input iclass_e prod,
        input iclass_e cons,
        input int      l_fp_fp,
        input int      l_fp_st,
        input int      l_ld_fp,
        input int      l_ld_st,
        input int      l_int_br
    );
        int lat;
        lat = 0;
        case (prod)
            CLS_FPALU: begin
                if (cons == CLS_FPALU)  lat = l_fp_fp;
                if (cons == CLS_STORED) lat = l_fp_st;
            end
            CLS_LOADD: begin
                if (cons == CLS_FPALU)  lat = l_ld_fp;
                if (cons == CLS_STORED) lat = l_ld_st;
            end
            CLS_INTALU: begin
                if (cons == CLS_BRANCH) lat = l_int_br;
            end
            default: lat = 0;
        endcase
        return lat;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilk_history.sv
// Module: issue-slot history.
// Shifts one slot per clock. Slot 0 holds the slot issued in the previous
// cycle. A bubble cycle shifts in an empty slot, so a slot's index equals the
// number of slots issued after it. Assumes DEPTH covers the largest latency.
module ilk_history #(
    parameter int REG_W = 5,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic                   push_we,
    input  logic [REG_W-1:0]       push_dst,
    input  logic [2:0]             push_cls,
    output logic [DEPTH-1:0]       hv,
    output logic [DEPTH*REG_W-1:0] hd,
    output logic [DEPTH*3-1:0]     hc
);

    logic [DEPTH-1:0]       v_q;
    logic [DEPTH*REG_W-1:0] d_q;
    logic [DEPTH*3-1:0]     c_q;

    // Slot 0 loads the newly issued producer or an empty bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q[0]         <= 1'b0;
            d_q[REG_W-1:0] <= '0;
            c_q[2:0]       <= '0;
        end else begin
            v_q[0]         <= push && push_we;
            d_q[REG_W-1:0] <= push_dst;
            c_q[2:0]       <= push_cls;
        end
    end

    // Older slots age by one position per cycle.
    for (genvar k = 1; k < DEPTH; k++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[k]                 <= 1'b0;
                d_q[k*REG_W +: REG_W]  <= '0;
                c_q[k*3 +: 3]          <= '0;
            end else begin
                v_q[k]                 <= v_q[k-1];
                d_q[k*REG_W +: REG_W]  <= d_q[(k-1)*REG_W +: REG_W];
                c_q[k*3 +: 3]          <= c_q[(k-1)*3 +: 3];
            end
        end
    end

    assign hv = v_q;
    assign hd = d_q;
    assign hc = c_q;

endmodule

// File: rtl/ilk_src_check.sv
// Module: per-source requirement.
// Finds the youngest history slot writing this source and returns the stall
// still owed: pair latency minus slots already elapsed, floored at zero.
module ilk_src_check
    import ilk_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int DEPTH    = 4,
    parameter int CNT_W    = 3,
    parameter int LAT_FF   = 3,
    parameter int LAT_FS   = 2,
    parameter int LAT_LF   = 1,
    parameter int LAT_LS   = 0,
    parameter int LAT_IB   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_W-1:0]       src,
    input  logic                   src_vld,
    input  logic [2:0]             cons_cls,
    input  logic [DEPTH-1:0]       hv,
    input  logic [DEPTH*REG_W-1:0] hd,
    input  logic [DEPTH*3-1:0]     hc,
    output logic [CNT_W-1:0]       need
);

    int lat;
    int rem;

    // Scan oldest to youngest so the youngest matching writer wins.
    always_comb begin
        lat = 0;
        rem = 0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (src_vld && hv[k] && (hd[k*REG_W +: REG_W] == src)) begin
                lat = pair_latency(iclass_e'(hc[k*3 +: 3]), iclass_e'(cons_cls),
                                   LAT_FF, LAT_FS, LAT_LF, LAT_LS, LAT_IB);
                rem = (lat > k) ? (lat - k) : 0;
            end
        end
        need = CNT_W'(rem);
    end

    AST_UNREAD_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !src_vld |-> need == '0); // R13

endmodule

// File: rtl/ilk_issue_ctrl.sv
// Module: hold/release and control penalty.
// Combines the per-source requirements with the branch bubble. Holds decode
// while anything is owed and tracks a branch that left its delay slot unused.
module ilk_issue_ctrl
    import ilk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [2:0]       dec_cls,
    input  logic             dec_slot_used,
    input  logic [CNT_W-1:0] need_a,
    input  logic [CNT_W-1:0] need_b,
    output logic             stall,
    output logic             issue,
    output logic [CNT_W-1:0] stall_cnt,
    output logic             ctl_penalty
);

    logic             pen_q;
    logic [CNT_W-1:0] data_need;
    logic [CNT_W-1:0] owed;

    // Largest of both data requirements and the control bubble.
    always_comb begin
        data_need = (need_a > need_b) ? need_a : need_b;
        owed      = (pen_q && data_need == '0) ? CNT_W'(1) : data_need;
        stall_cnt = dec_valid ? owed : '0;
        stall     = dec_valid && (owed != '0);
        issue     = dec_valid && (owed == '0);
    end

    // Flag the cycle after a branch issues without a filled delay slot.
    always_ff @(posedge clk) begin
        if (!rst_n) pen_q <= 1'b0;
        else        pen_q <= issue && (iclass_e'(dec_cls) == CLS_BRANCH) && !dec_slot_used;
    end

    assign ctl_penalty = pen_q;

    AST_PEN_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_penalty |-> $past(issue)); // R12
    AST_PEN_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_penalty |=> !ctl_penalty); // R12

endmodule

// File: rtl/ilk_interlock_unit.sv
// Module: top of the decode interlock.
// Per-source requirement checkers read a shared slot history. The issue
// controller turns their results into hold/release. Assumes HIST_DEPTH is at
// least the largest latency parameter and that decode keeps the descriptor
// steady while stall is high.
module ilk_interlock_unit
    import ilk_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int LAT_FP_FP  = 3,
    parameter int LAT_FP_ST  = 2,
    parameter int LAT_LD_FP  = 1,
    parameter int LAT_LD_ST  = 0,
    parameter int LAT_INT_BR = 1,
    parameter int HIST_DEPTH = 4,
    localparam int MAX_LAT   = imax(imax(imax(LAT_FP_FP, LAT_FP_ST),
                                         imax(LAT_LD_FP, LAT_LD_ST)),
                                    imax(LAT_INT_BR, 1)),
    localparam int CNT_W     = $clog2(MAX_LAT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [2:0]       dec_cls,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_dst_we,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic             dec_src_a_vld,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             dec_src_b_vld,
    input  logic             dec_slot_used,
    output logic             stall,
    output logic             issue,
    output logic [CNT_W-1:0] stall_cnt,
    output logic             ctl_penalty
);

    localparam int N_SRC = 2;

    logic [HIST_DEPTH-1:0]       hv;
    logic [HIST_DEPTH*REG_W-1:0] hd;
    logic [HIST_DEPTH*3-1:0]     hc;
    logic [REG_W-1:0]            src   [N_SRC];
    logic                        src_v [N_SRC];
    logic [CNT_W-1:0]            need  [N_SRC];

    assign src[0]   = dec_src_a;
    assign src[1]   = dec_src_b;
    assign src_v[0] = dec_src_a_vld;
    assign src_v[1] = dec_src_b_vld;

    ilk_history #(
        .REG_W (REG_W),
        .DEPTH (HIST_DEPTH)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (issue),
        .push_we  (dec_dst_we),
        .push_dst (dec_dst),
        .push_cls (dec_cls),
        .hv       (hv),
        .hd       (hd),
        .hc       (hc)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        ilk_src_check #(
            .REG_W  (REG_W),
            .DEPTH  (HIST_DEPTH),
            .CNT_W  (CNT_W),
            .LAT_FF (LAT_FP_FP),
            .LAT_FS (LAT_FP_ST),
            .LAT_LF (LAT_LD_FP),
            .LAT_LS (LAT_LD_ST),
            .LAT_IB (LAT_INT_BR)
        ) u_chk (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src[s]),
            .src_vld  (src_v[s]),
            .cons_cls (dec_cls),
            .hv       (hv),
            .hd       (hd),
            .hc       (hc),
            .need     (need[s])
        );
    end

    ilk_issue_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec_valid     (dec_valid),
        .dec_cls       (dec_cls),
        .dec_slot_used (dec_slot_used),
        .need_a        (need[0]),
        .need_b        (need[1]),
        .stall         (stall),
        .issue         (issue),
        .stall_cnt     (stall_cnt),
        .ctl_penalty   (ctl_penalty)
    );

    logic [3*REG_W+6:0] desc;
    assign desc = {dec_cls, dec_dst, dec_dst_we, dec_src_a, dec_src_a_vld,
                   dec_src_b, dec_src_b_vld, dec_slot_used};

    AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !stall); // R1
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && stall_cnt != '0) |=>
            (!dec_valid || !$stable(desc) || stall_cnt == $past(stall_cnt) - 1'b1)); // R11

endmodule

// File: tb/tb_ilk_interlock_unit.sv
`timescale 1ns/1ps
module tb_ilk_interlock_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [2:0] dec_cls = '0;
    logic [4:0] dec_dst = '0;
    logic       dec_dst_we = 1'b0;
    logic [4:0] dec_src_a = '0;
    logic       dec_src_a_vld = 1'b0;
    logic [4:0] dec_src_b = '0;
    logic       dec_src_b_vld = 1'b0;
    logic       dec_slot_used = 1'b0;
    logic       stall, issue, ctl_penalty;
    logic [2:0] stall_cnt;

    ilk_interlock_unit dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_dst(dec_dst), .dec_dst_we(dec_dst_we),
        .dec_src_a(dec_src_a), .dec_src_a_vld(dec_src_a_vld),
        .dec_src_b(dec_src_b), .dec_src_b_vld(dec_src_b_vld),
        .dec_slot_used(dec_slot_used), .stall(stall), .issue(issue),
        .stall_cnt(stall_cnt), .ctl_penalty(ctl_penalty)
    );

    always #2 clk = ~clk;

    localparam int FP = 0, LD = 1, ST = 2, IA = 3, BR = 4;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model: last writer of each register.
    bit tab_v [32];
    int tab_c [32];
    int tab_t [32];
    int pen_issue = -100;
    int pen_cycle = -1;

    int    exp_q [$];
    string tag_q [$];
    int    waited = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lat_of(input int p, input int c);
        if (p == FP && c == FP) return 3;
        if (p == FP && c == ST) return 2;
        if (p == LD && c == FP) return 1;
        if (p == LD && c == ST) return 0;
        if (p == IA && c == BR) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        for (int r = 0; r < 32; r++) tab_v[r] = 1'b0;
        pen_issue = -100;
        pen_cycle = -1;
    endtask

    // Driver: compute expected wait, push it, present the instruction until issue.
    task automatic send(input int cls, input int dst, input bit we,
                        input int sa, input bit sav, input int sb, input bit sbv,
                        input bit slot, input string tag);
        int t, w;
        @(posedge clk); #1;
        t = cyc;
        w = 0;
        if (sav && tab_v[sa]) w = (tab_t[sa] + 1 + lat_of(tab_c[sa], cls) - t > w) ?
                                  tab_t[sa] + 1 + lat_of(tab_c[sa], cls) - t : w;
        if (sbv && tab_v[sb]) w = (tab_t[sb] + 1 + lat_of(tab_c[sb], cls) - t > w) ?
                                  tab_t[sb] + 1 + lat_of(tab_c[sb], cls) - t : w;
        if (pen_issue + 2 - t > w) w = pen_issue + 2 - t;
        exp_q.push_back(w);
        tag_q.push_back(tag);
        if (we) begin
            tab_v[dst] = 1'b1;
            tab_c[dst] = cls;
            tab_t[dst] = t + w;
        end
        if (cls == BR && !slot) begin
            pen_issue = t + w;
            pen_cycle = t + w + 1;
        end
        dec_valid = 1'b1;  dec_cls = 3'(cls);
        dec_dst = 5'(dst); dec_dst_we = we;
        dec_src_a = 5'(sa); dec_src_a_vld = sav;
        dec_src_b = 5'(sb); dec_src_b_vld = sbv;
        dec_slot_used = slot;
        forever begin
            @(negedge clk);
            if (issue) break;
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        dec_valid = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        dec_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        clear_model();
        waited = 0;
    endtask

    // Monitor: compare first-cycle count and total wait against the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_valid && exp_q.size() > 0) begin
                if (waited == 0)
                    check(stall_cnt == 3'(exp_q[0]), {tag_q[0], " stall_cnt R11"},
                          int'(stall_cnt), exp_q[0]);
                if (issue) begin
                    check(waited == exp_q[0], {tag_q[0], " wait R11"}, waited, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                    waited = 0;
                end else begin
                    waited++;
                end
            end
            if (ctl_penalty || cyc == pen_cycle)
                check(ctl_penalty == (cyc == pen_cycle), "R12 ctl_penalty",
                      int'(ctl_penalty), int'(cyc == pen_cycle));
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_model();
        do_reset();
        @(negedge clk);
        check(!stall && !issue && !ctl_penalty && stall_cnt == 0, "R1 idle outputs",
              int'({stall, issue, ctl_penalty, stall_cnt}), 0);

        send(FP, 1, 1, 0, 0, 0, 0, 0, "R1 first");
        send(FP, 2, 1, 1, 1, 0, 0, 0, "R2 fp->fp");
        send(FP, 3, 1, 9, 0, 0, 0, 0, "R2 producer");
        send(IA, 20, 1, 21, 1, 0, 0, 0, "R7 filler");
        send(ST, 0, 0, 22, 1, 3, 1, 0, "R3 R8 fp->st one between");
        send(LD, 4, 1, 23, 1, 0, 0, 0, "R4 load");
        send(FP, 5, 1, 4, 1, 0, 0, 0, "R4 ld->fp");
        send(LD, 6, 1, 23, 1, 0, 0, 0, "R5 load");
        send(ST, 0, 0, 23, 1, 6, 1, 0, "R5 ld->st");
        send(IA, 7, 1, 0, 0, 0, 0, 0, "R6 int");
        send(BR, 0, 0, 7, 1, 0, 0, 1, "R6 int->br slot");
        send(IA, 8, 1, 0, 0, 0, 0, 0, "R12 no penalty with slot");
        send(BR, 0, 0, 8, 1, 0, 0, 0, "R6 int->br no slot");
        send(IA, 9, 1, 0, 0, 0, 0, 0, "R12 penalty hold");
        send(FP, 10, 1, 0, 0, 0, 0, 0, "R7 fp prod");
        send(IA, 11, 1, 10, 1, 0, 0, 0, "R7 fp->int");
        send(FP, 12, 1, 11, 1, 0, 0, 0, "R7 int->fp");
        send(FP, 13, 1, 0, 0, 0, 0, 0, "R9 fp prod");
        send(LD, 14, 1, 0, 0, 0, 0, 0, "R9 ld prod");
        send(FP, 15, 1, 13, 1, 14, 1, 0, "R9 two sources");
        send(FP, 16, 1, 0, 0, 0, 0, 0, "R10 older fp");
        send(LD, 16, 1, 0, 0, 0, 0, 0, "R10 younger ld");
        send(FP, 17, 1, 16, 1, 0, 0, 0, "R10 youngest wins");
        send(FP, 18, 1, 0, 0, 0, 0, 0, "R8 prod");
        idle(2);
        send(FP, 19, 1, 18, 1, 0, 0, 0, "R8 after two idle");
        idle(4);
        send(FP, 24, 1, 19, 1, 0, 0, 0, "R8 after four idle");
        send(FP, 25, 1, 0, 0, 0, 0, 0, "R13 prod");
        send(FP, 26, 1, 25, 0, 25, 0, 0, "R13 unread src");
        send(ST, 27, 0, 0, 0, 0, 0, 0, "R13 non-writer");
        send(FP, 28, 1, 27, 1, 0, 0, 0, "R13 no producer");
        send(FP, 29, 1, 0, 0, 0, 0, 0, "R1 pending prod");
        do_reset();
        send(FP, 30, 1, 29, 1, 29, 1, 0, "R1 after reset");
        idle(3);
        check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule